// File: doc/BRIEF.md
# Multi-Timer Bank

A register-mapped timer peripheral on a plain 32-bit register bus. It holds three auto-reloading down-counters and one wide up-counter. The first two down-counters are 16 bits wide and the third is 32 bits wide. Each down-counter has four registers: a reload value, a live count, a mode/enable word and an interrupt-clear port. Each one drives a level interrupt when it underflows. The fourth counter is 40 bits wide and free-running. It is started and stopped by a bit in its upper register and never interrupts.

Counting is driven by single-cycle tick strobes from an external divider. There is a fast strobe and a slow strobe for the down-counters, and a third strobe for the wide counter. Each down-counter picks its strobe through its mode word.

A typical setup for a periodic system interrupt is three steps. First write the reload value N. Then set enable, periodic mode and the fast source. The interrupt then fires every N+1 fast ticks, and software acknowledges it by writing anything to the clear port. Reads are combinational from the address; writes take effect on the next clock edge.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every count, reload value and mode word reads zero, all interrupts are low, and the wide counter is stopped at zero.
- R2: Writing a reload register stores the value (truncated to the timer width) and copies it into the live count at the same edge. The count register reads the live count zero-extended to 32 bits.
- R3: In the mode word, bit 7 is enable, bit 6 is periodic mode and bit 3 is fast-source select. It reads back with only those three bits possibly set.
- R4: An enabled down-counter decrements once per fast strobe when bit 3 is set, and once per slow strobe when bit 3 is clear. A disabled counter holds its count and raises no new interrupt.
- R5: In periodic mode, a tick at count zero reloads the count from the reload register and sets the interrupt, so reload value N gives a period of N+1 ticks.
- R6: In free-running mode (bit 6 clear), a tick at count zero wraps the count to all ones for the timer width and still sets the interrupt.
- R7: Each interrupt is a level that stays high from the underflow until a write of any data to that timer's clear port. An underflow in the same cycle as the clear leaves it set.
- R8: The timers sit at base offsets 0x00, 0x20 and 0x80, each with reload at +0x0, count at +0x4, mode at +0x8 and clear at +0xC. The wide counter's low word is at 0x60 and its high word at 0x64. Other addresses read zero and ignore writes.
- R9: The wide counter increments by one per wide strobe while its enable is set, wraps modulo 2^40, and holds while disabled.
- R10: Bit 8 of the word written to 0x64 sets the wide enable. Reading 0x64 returns count bits 39:32 in bits 7:0 and the enable in bit 8; reading 0x60 returns count bits 31:0.
- R11: Widths differ per timer: timers at 0x00 and 0x20 keep 16 bits (wrap value 0xFFFF), and the timer at 0x80 keeps 32 bits (wrap value 0xFFFFFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fast_tick_i | input | 1 | Fast tick strobe for the down-counters |
| slow_tick_i | input | 1 | Slow tick strobe for the down-counters |
| wide_tick_i | input | 1 | Tick strobe for the 40-bit counter |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 3 | Level interrupts, bit i for down-counter i |

## Verification
The assertions check these rules on every cycle:
- the interrupt stays set until a clear;
- a disabled down-counter neither moves nor raises a new interrupt;
- a reload write lands in the count at the next edge;
- underflow goes to the reload value or to all ones, depending on mode;
- the wide counter steps by exactly one per enabled strobe, wrapping at 2^40, and holds otherwise.

Only the bench scenarios can show the rest:
- the address map and the three-bit read-back of the mode word;
- truncation to each timer's width;
- the choice between fast and slow strobes;
- the N+1 period counted at the bus;
- the layout of the wide counter's high word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_DOWN = 3;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned WIDE_W   = 40;

  localparam int unsigned CTRL_EN_BIT   = 7;
  localparam int unsigned CTRL_PER_BIT  = 6;
  localparam int unsigned CTRL_FAST_BIT = 3;
  localparam int unsigned WIDE_EN_BIT   = 8;

  localparam logic [ADDR_W-1:0] WIDE_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] WIDE_HI_ADDR = 8'h64;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_MODE  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast_sel;
  } mode_t;

  function automatic int unsigned down_width(input int unsigned idx);
    return (idx == 2) ? 32 : 16;
  endfunction

  function automatic logic [ADDR_W-1:0] down_base(input int unsigned idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] mode_word(input mode_t m);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = m.en;
    w[CTRL_PER_BIT]  = m.periodic;
    w[CTRL_FAST_BIT] = m.fast_sel;
    return w;
  endfunction
endpackage

// File: rtl/tmr_down_ctr.sv
module tmr_down_ctr
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic             load_we_i,
  input  logic             mode_we_i,
  input  logic             clr_we_i,
  input  logic [CNT_W-1:0] load_wdata_i,
  input  mode_t            mode_wdata_i,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cnt_o,
  output mode_t            mode_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] load_q, cnt_q, cnt_d;
  mode_t            mode_q;
  logic             irq_q, irq_d;
  logic             tick, underflow;

  assign tick      = mode_q.en & (mode_q.fast_sel ? fast_tick_i : slow_tick_i);
  assign underflow = tick & (cnt_q == '0) & ~load_we_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_we_i)             cnt_d = load_wdata_i;
    else if (tick) begin
      if (cnt_q == '0)         cnt_d = mode_q.periodic ? load_q : '1;
      else                     cnt_d = cnt_q - 1'b1;
    end
  end

  // set beats clear when both land in one cycle
  assign irq_d = (irq_q & ~clr_we_i) | underflow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (load_we_i) load_q <= load_wdata_i;
      if (mode_we_i) mode_q <= mode_wdata_i;
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_we_i |=> irq_q);

  p_hold_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.en && !load_we_i |=> $stable(cnt_q));

  p_no_irq_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.en && !irq_q |=> !irq_q);

  p_load_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> cnt_q == $past(load_wdata_i));

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.en && mode_q.periodic && mode_q.fast_sel && fast_tick_i &&
    cnt_q == '0 && !load_we_i |=> cnt_q == $past(load_q) && irq_q);

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.en && !mode_q.periodic && !mode_q.fast_sel && slow_tick_i &&
    cnt_q == '0 && !load_we_i |=> cnt_q == '1 && irq_q);
endmodule

// File: rtl/tmr_wide_ctr.sv
module tmr_wide_ctr #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (en_we_i)        en_q  <= en_wdata_i;
      if (en_q && tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;

  p_wide_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && tick_i |=> cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1});

  p_wide_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_q && tick_i) |=> $stable(cnt_q));

  p_wide_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> en_q == $past(en_wdata_i));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fast_tick_i,
  input  logic                slow_tick_i,
  input  logic                wide_tick_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic [NUM_DOWN-1:0] irq_o
);
  localparam int unsigned HI_W = WIDE_W - BUS_W;

  logic [NUM_DOWN-1:0] hit;
  logic [BUS_W-1:0]    load_rd [NUM_DOWN];
  logic [BUS_W-1:0]    cnt_rd  [NUM_DOWN];
  logic [BUS_W-1:0]    mode_rd [NUM_DOWN];
  reg_sel_e            rsel;
  mode_t               mode_wdata;

  assign rsel       = reg_sel_e'(addr_i[3:2]);
  assign mode_wdata = '{en:       wdata_i[CTRL_EN_BIT],
                        periodic: wdata_i[CTRL_PER_BIT],
                        fast_sel: wdata_i[CTRL_FAST_BIT]};

  for (genvar gi = 0; gi < NUM_DOWN; gi++) begin : g_down
    localparam int unsigned     W    = down_width(gi);
    localparam logic [ADDR_W-1:0] BASE = down_base(gi);
    logic [W-1:0] load_w, cnt_w;
    mode_t        mode_w;
    logic         irq_w;

    assign hit[gi] = (addr_i[7:4] == BASE[7:4]) && (addr_i[1:0] == 2'b00);

    tmr_down_ctr #(.CNT_W(W)) u_ctr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fast_tick_i  (fast_tick_i),
      .slow_tick_i  (slow_tick_i),
      .load_we_i    (wr_i && hit[gi] && rsel == REG_LOAD),
      .mode_we_i    (wr_i && hit[gi] && rsel == REG_MODE),
      .clr_we_i     (wr_i && hit[gi] && rsel == REG_CLEAR),
      .load_wdata_i (wdata_i[W-1:0]),
      .mode_wdata_i (mode_wdata),
      .load_o       (load_w),
      .cnt_o        (cnt_w),
      .mode_o       (mode_w),
      .irq_o        (irq_w)
    );

    assign load_rd[gi] = 32'(load_w);
    assign cnt_rd[gi]  = 32'(cnt_w);
    assign mode_rd[gi] = mode_word(mode_w);
    assign irq_o[gi]   = irq_w;
  end

  logic [WIDE_W-1:0] wide_cnt;
  logic              wide_en;

  tmr_wide_ctr #(.CNT_W(WIDE_W)) u_wide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (wide_tick_i),
    .en_we_i    (wr_i && addr_i == WIDE_HI_ADDR),
    .en_wdata_i (wdata_i[WIDE_EN_BIT]),
    .cnt_o      (wide_cnt),
    .en_o       (wide_en)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_DOWN; i++) begin
      if (hit[i]) begin
        case (rsel)
          REG_LOAD:  rdata_o = load_rd[i];
          REG_COUNT: rdata_o = cnt_rd[i];
          REG_MODE:  rdata_o = mode_rd[i];
          default:   rdata_o = '0;
        endcase
      end
    end
    if (addr_i == WIDE_LO_ADDR) rdata_o = wide_cnt[BUS_W-1:0];
    if (addr_i == WIDE_HI_ADDR) begin
      rdata_o[HI_W-1:0]    = wide_cnt[WIDE_W-1:BUS_W];
      rdata_o[WIDE_EN_BIT] = wide_en;
    end
  end

  p_one_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_tick = 1'b0, slow_tick = 1'b0, wide_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr_bank u_tmr_bank (
    .clk_i(clk), .rst_ni(rst_n), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .wide_tick_i(wide_tick), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] BASES [3] = '{8'h00, 8'h20, 8'h80};

  logic [31:0] m_cnt [3];
  logic [31:0] m_load [3];
  logic [31:0] m_mask [3];
  bit          m_en [3], m_per [3], m_fast [3], m_irq [3];
  logic [39:0] m_w;
  bit          m_wen;

  function automatic logic [31:0] exp_mode(input bit en, input bit per, input bit fst);
    return {24'd0, en, per, 2'b00, fst, 3'b000};
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    for (int i = 0; i < 3; i++) begin
      if (a == BASES[i])        begin m_load[i] = d & m_mask[i]; m_cnt[i] = d & m_mask[i]; end
      if (a == BASES[i] + 8'h8) begin m_en[i] = d[7]; m_per[i] = d[6]; m_fast[i] = d[3]; end
      if (a == BASES[i] + 8'hC) m_irq[i] = 1'b0;
    end
    if (a == 8'h64) m_wen = d[8];
  endtask

  task automatic model_tick(input bit ft, input bit st, input bit wt);
    for (int i = 0; i < 3; i++) begin
      if (m_en[i] && (m_fast[i] ? ft : st)) begin
        if (m_cnt[i] == 0) begin
          m_cnt[i] = m_per[i] ? m_load[i] : m_mask[i];
          m_irq[i] = 1'b1;
        end else m_cnt[i] = m_cnt[i] - 1;
      end
    end
    if (m_wen && wt) m_w = m_w + 40'd1;
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    fast_tick = 0; slow_tick = 0; wide_tick = 0;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input bit ft, input bit st, input bit wt);
    @(negedge clk);
    fast_tick = ft; slow_tick = st; wide_tick = wt;
    @(posedge clk);
    model_tick(ft, st, wt);
    @(negedge clk);
    fast_tick = 0; slow_tick = 0; wide_tick = 0;
  endtask

  task automatic chk_count(input string req, input int t);
    logic [31:0] v;
    bus_read(BASES[t] + 8'h4, v);
    chk(req, $sformatf("count t%0d", t), {32'd0, v}, {32'd0, m_cnt[t]});
  endtask

  task automatic chk_irq(input string req);
    chk(req, "irq", {61'd0, irq}, {61'd0, m_irq[2], m_irq[1], m_irq[0]});
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3; i++) begin
      m_cnt[i] = 0; m_load[i] = 0; m_en[i] = 0; m_per[i] = 0; m_fast[i] = 0; m_irq[i] = 0;
      m_mask[i] = (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    end
    m_w = 0; m_wen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      bus_read(BASES[i], v);        chk("R1", "load after reset", {32'd0, v}, 64'd0);
      bus_read(BASES[i] + 8'h4, v); chk("R1", "count after reset", {32'd0, v}, 64'd0);
      bus_read(BASES[i] + 8'h8, v); chk("R1", "mode after reset", {32'd0, v}, 64'd0);
    end
    bus_read(8'h64, v); chk("R1", "wide hi after reset", {32'd0, v}, 64'd0);
    chk("R1", "irq after reset", {61'd0, irq}, 64'd0);

    // R2 load copies into count; R11 widths
    bus_write(8'h00, 32'd5);
    bus_read(8'h04, v); chk("R2", "count after load", {32'd0, v}, 64'd5);
    bus_read(8'h00, v); chk("R2", "load readback", {32'd0, v}, 64'd5);
    bus_write(8'h80, 32'h1234_5678);
    bus_read(8'h84, v); chk("R11", "32-bit load", {32'd0, v}, 64'h1234_5678);
    bus_write(8'h20, 32'h000A_BCDE);
    bus_read(8'h24, v); chk("R11", "16-bit truncation", {32'd0, v}, 64'hBCDE);

    // R3 mode read-back
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_read(8'h28, v); chk("R3", "mode readback", {32'd0, v}, 64'hC8);
    bus_write(8'h28, 32'h0);

    // R5 periodic reload on t0, fast source; R4 slow ignored
    bus_write(8'h00, 32'd3);
    bus_write(8'h08, exp_mode(1, 1, 1));
    pulse(0, 1, 0); pulse(0, 1, 0);
    bus_read(8'h04, v); chk("R4", "slow strobe ignored when fast selected", {32'd0, v}, 64'd3);
    repeat (3) pulse(1, 0, 0);
    bus_read(8'h04, v); chk("R5", "count at zero", {32'd0, v}, 64'd0);
    chk("R5", "no irq before underflow", {61'd0, irq}, 64'd0);
    pulse(1, 0, 0);
    bus_read(8'h04, v); chk("R5", "reloaded after N+1 ticks", {32'd0, v}, 64'd3);
    chk("R5", "irq on underflow", {61'd0, irq}, 64'd1);

    // R7 level held until clear, cleared by any data
    bus_write(8'h20, 32'd7);
    chk("R7", "irq held across unrelated write", {61'd0, irq}, 64'd1);
    bus_write(8'h0C, 32'h0);
    chk("R7", "clear with zero data", {61'd0, irq}, 64'd0);

    // R6 free-running wrap, slow source; R11 widths
    bus_write(8'h20, 32'd0);
    bus_write(8'h28, exp_mode(1, 0, 0));
    pulse(0, 1, 0);
    bus_read(8'h24, v); chk("R6", "16-bit wrap", {32'd0, v}, 64'hFFFF);
    chk("R6", "irq on wrap", {61'd0, irq[1]}, 64'd1);
    bus_write(8'h80, 32'd0);
    bus_write(8'h88, exp_mode(1, 0, 0));
    pulse(0, 1, 0);
    bus_read(8'h84, v); chk("R11", "32-bit wrap", {32'd0, v}, 64'hFFFF_FFFF);
    chk_count("R4", 1);
    chk_irq("R6");

    // R4 disabled counter holds, no new irq
    bus_write(8'h08, 32'h0);
    bus_write(8'h00, 32'd0);
    pulse(1, 1, 0);
    bus_read(8'h04, v); chk("R4", "disabled holds", {32'd0, v}, 64'd0);
    chk("R4", "disabled no irq", {61'd0, irq[0]}, 64'd0);

    // R8 unmapped address
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read(8'h40, v); chk("R8", "unmapped reads zero", {32'd0, v}, 64'd0);
    bus_read(8'h20, v); chk("R8", "unmapped write ignored", {32'd0, v}, 64'd0);

    // R9/R10 wide counter
    pulse(0, 0, 1);
    bus_read(8'h60, v); chk("R9", "wide stopped", {32'd0, v}, 64'd0);
    bus_write(8'h64, 32'h100);
    bus_read(8'h64, v); chk("R10", "wide hi enable bit", {32'd0, v}, 64'h100);
    repeat (3) pulse(0, 0, 1);
    bus_read(8'h60, v); chk("R9", "wide increments", {32'd0, v}, 64'd3);
    bus_write(8'h64, 32'h0);
    pulse(0, 0, 1);
    bus_read(8'h60, v); chk("R9", "wide holds when disabled", {32'd0, v}, 64'd3);
    bus_read(8'h64, v); chk("R10", "wide hi disabled", {32'd0, v}, 64'h0);
    bus_write(8'h64, 32'h100);

    // Random phase against the bench model
    for (int i = 0; i < 3; i++) begin
      bus_write(BASES[i] + 8'hC, 32'h0);
      bus_write(BASES[i], $urandom % 12);
      bus_write(BASES[i] + 8'h8, exp_mode(1, 1'($urandom), 1'($urandom)));
    end
    for (int k = 0; k < 600; k++) begin
      if ($urandom % 16 == 0) bus_write(BASES[$urandom % 3] + 8'hC, $urandom);
      if ($urandom % 40 == 0) bus_write(BASES[$urandom % 3] + 8'h8,
                                        exp_mode(1'($urandom), 1'($urandom), 1'($urandom)));
      @(negedge clk);
      fast_tick = ($urandom % 3 == 0); slow_tick = ($urandom % 4 == 0); wide_tick = 1'($urandom);
      @(posedge clk);
      model_tick(fast_tick, slow_tick, wide_tick);
      @(negedge clk);
      fast_tick = 0; slow_tick = 0; wide_tick = 0;
      chk_irq("R7");
      chk_count("R5", k % 3);
    end
    bus_read(8'h60, v); chk("R9", "wide count random", {32'd0, v}, {32'd0, m_w[31:0]});
    bus_read(8'h64, v); chk("R10", "wide hi random", {32'd0, v}, {55'd0, m_wen, m_w[39:32]});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule